// File: doc/BRIEF.md
# Broadcast Channel-Addressed Control Front-End

This block is the command front-end for a four-channel device. A host presents simple command and data strobes. One register, the channel enable mask, decides which channels a write reaches. A single configuration write is copied to every enabled channel at once: a single channel, any subset, or all four together for a broadcast. Reads return the data of one channel. If more than one channel is enabled during a read, the lowest-numbered enabled channel answers and a sticky error flag records the misuse.

The block also watches the serial chip-select and serial clock lines. If chip select stays low across sixteen serial clock rising edges, a one-cycle internal reset is issued when chip select goes high again. A clock-fail flag is set after every reset. It clears a fixed number of cycles after the host selects a master clock source. Until it clears, writes that activate channels are dropped, while all other configuration writes still go through.

Top module: `bcast_ctl_frontend`

## Requirements
- R1: A write with command 0x4A loads bits [3:0] of the write data into the enable mask, where bit i addresses channel i+1. A read with command 0x4A returns the mask zero-extended to 8 bits.
- R2: A write with any command other than 0x4A, 0x46, 0x0E, 0x0F or 0x5A drives `ch_wr_o` equal to the enable mask for exactly the one cycle after the strobe, with the command on `ch_cmd_o` and the data on `ch_wdata_o`. A mask of 0 reaches no channel.
- R3: After reset, the enable mask, the active bits, the error flag and the clock-select byte are 0, and `clk_fail_o` is 1.
- R4: A write with command 0x46 stores the clock-select byte. `pclk_mode_o` is bit 4 of that byte, `freq_sel_o` is bits [3:0], and a read with command 0x46 returns the whole byte.
- R5: `clk_fail_o` falls exactly LOCK_CYCLES clock edges after the edge that takes a 0x46 write. Once clear, it stays clear until the next reset.
- R6: Command 0x0E sets the active bits of all enabled channels, and command 0x0F clears them. While `clk_fail_o` is 1, command 0x0E is ignored.
- R7: Any other read returns, one cycle later on `rdata_o` with `rd_valid_o` high, the `ch_rdata_i` slice of the lowest-numbered enabled channel (channel 1 is bits [7:0]). The result is 0 if no channel is enabled.
- R8: A channel read with more than one bit set in the enable mask sets a sticky error flag. A read with command 0x5A returns a status byte: bit 7 is `clk_fail_o`, bit 6 is the error flag, and bits [3:0] are the active bits.
- R9: Chip select held low across 16 or more serial clock rising edges gives exactly one `soft_rst_o` pulse, one clock long, after chip select rises. Fewer edges give no pulse.
- R10: A `soft_rst_o` pulse restores every state of R3.
- R11: A low level on `rst_n` restores every state of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial data clock, sampled asynchronously |
| cs_n_i | input | 1 | Serial chip select, active low |
| wr_stb_i | input | 1 | Write command strobe |
| rd_stb_i | input | 1 | Read command strobe |
| cmd_i | input | 8 | Command code |
| wdata_i | input | 8 | Write data |
| ch_rdata_i | input | 32 | Readback data of the four channels, channel 1 in the low byte |
| ch_wr_o | output | 4 | Per-channel write strobe |
| ch_cmd_o | output | 8 | Command forwarded to the channels |
| ch_wdata_o | output | 8 | Data forwarded to the channels |
| rdata_o | output | 8 | Read result |
| rd_valid_o | output | 1 | Read result valid |
| chan_active_o | output | 4 | Activation bit of each channel |
| clk_fail_o | output | 1 | Clock not yet locked |
| pclk_mode_o | output | 1 | Internal clock is taken from the PCM clock |
| freq_sel_o | output | 4 | Selected master clock frequency code |
| soft_rst_o | output | 1 | Reset generated by a long chip-select pulse |

## Verification
The fan-out is driven with a single low channel, a single high channel, a two-channel middle pair, all four channels and an empty mask. These separate a decoder that drops, swaps or shifts channel bits from a correct copy of the mask, and they show whether an empty mask really leaves every channel untouched. Reads use one enabled channel, two enabled channels and no enabled channel. This tells a lowest-first choice from a highest-first choice and from a plain OR of the channel data, and shows that the error flag is set only for the two-channel case. Chip-select pulses of 15, 16 and 20 serial edges mark the exact threshold and check that the edge counter saturates. Activation is tried both before and after the clock lock, which separates a blocked command from an accepted one.

// File: rtl/ctlfe_pkg.sv
package ctlfe_pkg;
  typedef logic [7:0] cmd_t;

  localparam cmd_t CMD_CHAN_EN    = 8'h4A;
  localparam cmd_t CMD_CLK_SEL    = 8'h46;
  localparam cmd_t CMD_ACTIVATE   = 8'h0E;
  localparam cmd_t CMD_DEACTIVATE = 8'h0F;
  localparam cmd_t CMD_STATUS     = 8'h5A;

  // Commands handled inside the front-end and never forwarded to channels
  function automatic logic is_local_cmd(cmd_t c);
    return (c == CMD_CHAN_EN) || (c == CMD_CLK_SEL) || (c == CMD_ACTIVATE) ||
           (c == CMD_DEACTIVATE) || (c == CMD_STATUS);
  endfunction
endpackage

// File: rtl/ctlfe_sync.sv
module ctlfe_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/ctlfe_cs_watch.sv
module ctlfe_cs_watch #(
  parameter int LONG_EDGES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  output logic soft_rst_o
);
  localparam int CW = $clog2(LONG_EDGES + 1);
  localparam logic [CW-1:0] FULL = CW'(LONG_EDGES);

  logic sclk_s, cs_s, sclk_d, cs_d;
  logic [CW-1:0] edge_cnt;
  logic sclk_rise, cs_rise, cnt_full;

  ctlfe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(sclk_i), .q(sclk_s));
  ctlfe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(cs_n_i), .q(cs_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_rise   = cs_s & ~cs_d;
  assign cnt_full  = (edge_cnt == FULL);

  // Saturating count of serial edges seen while chip select is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          edge_cnt <= '0;
    else if (cs_rise)                    edge_cnt <= '0;
    else if (sclk_rise && !cs_s && !cnt_full) edge_cnt <= edge_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_rst_o <= 1'b0;
    else        soft_rst_o <= cs_rise & cnt_full;
  end

  assert_cnt_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= FULL);
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);
  assert_pulse_cs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> cs_d);
endmodule

// File: rtl/ctlfe_clk_track.sv
module ctlfe_clk_track #(
  parameter int DATA_W      = 8,
  parameter int LOCK_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_rst,
  input  logic              sel_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              clk_fail_o,
  output logic [DATA_W-1:0] clksel_o
);
  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam logic [LW-1:0] LOCK_LOAD = LW'(LOCK_CYCLES);

  logic [LW-1:0] lock_cnt;
  logic          pending;
  logic          lock_done;

  assign lock_done = pending && (lock_cnt == LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clksel_o   <= '0;
      clk_fail_o <= 1'b1;
      pending    <= 1'b0;
      lock_cnt   <= '0;
    end else if (gen_rst) begin
      clksel_o   <= '0;
      clk_fail_o <= 1'b1;
      pending    <= 1'b0;
      lock_cnt   <= '0;
    end else if (sel_wr) begin
      clksel_o <= wdata;
      if (clk_fail_o) begin
        pending  <= 1'b1;
        lock_cnt <= LOCK_LOAD;
      end
    end else if (lock_done) begin
      clk_fail_o <= 1'b0;
      pending    <= 1'b0;
    end else if (pending) begin
      lock_cnt <= lock_cnt - 1'b1;
    end
  end

  assert_fail_stays_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_fail_o && !gen_rst) |=> !clk_fail_o);
  assert_fall_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_fail_o) |-> $past(pending));
endmodule

// File: rtl/ctlfe_chan_dispatch.sv
module ctlfe_chan_dispatch
  import ctlfe_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gen_rst,
  input  logic                     wr_stb,
  input  logic                     rd_stb,
  input  cmd_t                     cmd,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_CH*DATA_W-1:0] ch_rdata,
  input  logic                     clk_fail,
  input  logic [DATA_W-1:0]        clksel,
  output logic [NUM_CH-1:0]        active_o,
  output logic [NUM_CH-1:0]        ch_wr_o,
  output cmd_t                     ch_cmd_o,
  output logic [DATA_W-1:0]        ch_wdata_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rd_valid_o
);
  function automatic int unsigned lowest_set(logic [NUM_CH-1:0] v);
    int unsigned r = 0;
    for (int i = NUM_CH - 1; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  function automatic int unsigned ones(logic [NUM_CH-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < NUM_CH; i++) n += v[i];
    return n;
  endfunction

  logic [NUM_CH-1:0] chen_q;
  logic              err_q;
  logic              fwd_wr, chen_wr, act_req, act_block, deact_req, multi_rd, chan_rd;
  logic [DATA_W-1:0] sel_data, stat_word, chen_word, rd_mux;

  assign chen_wr   = wr_stb && (cmd == CMD_CHAN_EN);
  assign fwd_wr    = wr_stb && !is_local_cmd(cmd);
  assign act_req   = wr_stb && (cmd == CMD_ACTIVATE);
  assign act_block = act_req && clk_fail;
  assign deact_req = wr_stb && (cmd == CMD_DEACTIVATE);
  assign chan_rd   = rd_stb && !is_local_cmd(cmd);
  assign multi_rd  = chan_rd && (ones(chen_q) > 1);

  always_comb begin
    sel_data = '0;
    if (chen_q != '0) sel_data = ch_rdata[lowest_set(chen_q)*DATA_W +: DATA_W];
    chen_word = '0;
    chen_word[NUM_CH-1:0] = chen_q;
    stat_word = '0;
    stat_word[NUM_CH-1:0] = active_o;
    stat_word[DATA_W-2]   = err_q;
    stat_word[DATA_W-1]   = clk_fail;
    case (cmd)
      CMD_CHAN_EN: rd_mux = chen_word;
      CMD_CLK_SEL: rd_mux = clksel;
      CMD_STATUS:  rd_mux = stat_word;
      default:     rd_mux = sel_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chen_q   <= '0;
      active_o <= '0;
      err_q    <= 1'b0;
    end else if (gen_rst) begin
      chen_q   <= '0;
      active_o <= '0;
      err_q    <= 1'b0;
    end else begin
      if (chen_wr) chen_q <= wdata[NUM_CH-1:0];
      if (act_req && !act_block) active_o <= active_o | chen_q;
      else if (deact_req)        active_o <= active_o & ~chen_q;
      if (multi_rd) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_wr_o    <= '0;
      ch_cmd_o   <= '0;
      ch_wdata_o <= '0;
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      ch_wr_o    <= (fwd_wr && !gen_rst) ? chen_q : '0;
      rd_valid_o <= rd_stb;
      if (fwd_wr) begin
        ch_cmd_o   <= cmd;
        ch_wdata_o <= wdata;
      end
      if (rd_stb) rdata_o <= rd_mux;
    end
  end

  assert_fanout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_wr && !gen_rst) |=> (ch_wr_o == $past(chen_q)));
  assert_strobe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_wr |=> (ch_wr_o == '0));
  assert_act_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_block && !gen_rst) |=> (active_o == $past(active_o)));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !gen_rst) |=> err_q);
  assert_multi_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_rd && !gen_rst) |=> err_q);
endmodule

// File: rtl/bcast_ctl_frontend.sv
module bcast_ctl_frontend
  import ctlfe_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 8,
  parameter int LONG_EDGES  = 16,
  parameter int LOCK_CYCLES = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_i,
  input  logic                     cs_n_i,
  input  logic                     wr_stb_i,
  input  logic                     rd_stb_i,
  input  logic [7:0]               cmd_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [NUM_CH*DATA_W-1:0] ch_rdata_i,
  output logic [NUM_CH-1:0]        ch_wr_o,
  output logic [7:0]               ch_cmd_o,
  output logic [DATA_W-1:0]        ch_wdata_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rd_valid_o,
  output logic [NUM_CH-1:0]        chan_active_o,
  output logic                     clk_fail_o,
  output logic                     pclk_mode_o,
  output logic [3:0]               freq_sel_o,
  output logic                     soft_rst_o
);
  logic              clksel_wr;
  logic [DATA_W-1:0] clksel;

  assign clksel_wr   = wr_stb_i && (cmd_i == CMD_CLK_SEL);
  assign pclk_mode_o = clksel[4];
  assign freq_sel_o  = clksel[3:0];

  ctlfe_cs_watch #(.LONG_EDGES(LONG_EDGES), .SYNC_STAGES(SYNC_STAGES)) u_cs_watch (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .cs_n_i(cs_n_i),
    .soft_rst_o(soft_rst_o));

  ctlfe_clk_track #(.DATA_W(DATA_W), .LOCK_CYCLES(LOCK_CYCLES)) u_clk_track (
    .clk(clk), .rst_n(rst_n), .gen_rst(soft_rst_o), .sel_wr(clksel_wr),
    .wdata(wdata_i), .clk_fail_o(clk_fail_o), .clksel_o(clksel));

  ctlfe_chan_dispatch #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dispatch (
    .clk(clk), .rst_n(rst_n), .gen_rst(soft_rst_o), .wr_stb(wr_stb_i),
    .rd_stb(rd_stb_i), .cmd(cmd_i), .wdata(wdata_i), .ch_rdata(ch_rdata_i),
    .clk_fail(clk_fail_o), .clksel(clksel), .active_o(chan_active_o),
    .ch_wr_o(ch_wr_o), .ch_cmd_o(ch_cmd_o), .ch_wdata_o(ch_wdata_o),
    .rdata_o(rdata_o), .rd_valid_o(rd_valid_o));

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> (chan_active_o == '0) && clk_fail_o && !pclk_mode_o);
  assert_rd_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> rd_valid_o);
  assert_mode_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clksel_wr && !soft_rst_o) |=> $stable(pclk_mode_o));
endmodule

// File: tb/bcast_ctl_frontend_tb.sv
module bcast_ctl_frontend_tb;
  localparam int LOCK = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, wr = 1'b0, rd = 1'b0;
  logic [7:0] cmd = '0, wdata = '0;
  logic [31:0] ch_rdata = 32'hD4C3B2A1;
  logic [3:0] ch_wr, active, freq;
  logic [7:0] ch_cmd, ch_wdata, rdata;
  logic rd_valid, clk_fail, pclk_mode, soft_rst;

  int checks = 0, fails = 0, pulses = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bcast_ctl_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .wr_stb_i(wr),
    .rd_stb_i(rd), .cmd_i(cmd), .wdata_i(wdata), .ch_rdata_i(ch_rdata),
    .ch_wr_o(ch_wr), .ch_cmd_o(ch_cmd), .ch_wdata_o(ch_wdata), .rdata_o(rdata),
    .rd_valid_o(rd_valid), .chan_active_o(active), .clk_fail_o(clk_fail),
    .pclk_mode_o(pclk_mode), .freq_sel_o(freq), .soft_rst_o(soft_rst));

  always @(posedge clk) if (soft_rst) pulses++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic [7:0] c, logic [7:0] d);
    @(negedge clk); wr = 1'b1; cmd = c; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_rd(logic [7:0] c, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; cmd = c;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic cs_pulse(int edges);
    @(negedge clk); cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < edges; i++) begin
      sclk = 1'b1; repeat (3) @(negedge clk);
      sclk = 1'b0; repeat (3) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [7:0] d;
    check("R3 clk_fail", clk_fail, 1);
    check("R3 active", active, 0);
    check("R3 ch_wr", ch_wr, 0);
    check("R3 pclk_mode", pclk_mode, 0);
    do_rd(8'h4A, d); check("R3 enable mask", d, 0);
    do_rd(8'h5A, d); check("R3 status", d, 8'h80);
  endtask

  task automatic fanout(logic [3:0] m, logic [7:0] c, logic [7:0] d);
    logic [7:0] r;
    do_wr(8'h4A, {4'hA, m});
    do_rd(8'h4A, r); check("R1 mask readback", r, {4'h0, m});
    @(negedge clk); wr = 1'b1; cmd = c; wdata = d;
    @(negedge clk); wr = 1'b0;
    check("R2 ch_wr", ch_wr, m);
    check("R2 ch_cmd", ch_cmd, c);
    check("R2 ch_wdata", ch_wdata, d);
    @(negedge clk); check("R2 strobe one cycle", ch_wr, 0);
  endtask

  task automatic t_fanout;
    fanout(4'b0001, 8'h20, 8'h11);
    fanout(4'b1000, 8'h21, 8'h22);
    fanout(4'b0110, 8'h30, 8'h5C);
    fanout(4'b1111, 8'h31, 8'hE7);
    fanout(4'b0000, 8'h32, 8'h99);
  endtask

  task automatic t_act_blocked;
    do_wr(8'h4A, 8'h0F);
    do_wr(8'h0E, 8'h00);
    @(negedge clk); check("R6 activate ignored while clk_fail", active, 0);
  endtask

  task automatic t_clk_lock;
    logic [7:0] d;
    @(negedge clk); wr = 1'b1; cmd = 8'h46; wdata = 8'h13;
    @(negedge clk); wr = 1'b0;
    check("R4 pclk_mode", pclk_mode, 1);
    check("R4 freq_sel", freq, 4'h3);
    repeat (LOCK - 1) @(negedge clk);
    check("R5 clk_fail before lock", clk_fail, 1);
    @(negedge clk);
    check("R5 clk_fail after lock", clk_fail, 0);
    do_rd(8'h46, d); check("R4 clksel readback", d, 8'h13);
  endtask

  task automatic t_activation;
    do_wr(8'h4A, 8'h05); do_wr(8'h0E, 8'h00);
    check("R6 activate 0101", active, 4'b0101);
    do_wr(8'h4A, 8'h02); do_wr(8'h0E, 8'h00);
    check("R6 activate add ch2", active, 4'b0111);
    do_wr(8'h4A, 8'h01); do_wr(8'h0F, 8'h00);
    check("R6 deactivate ch1", active, 4'b0110);
    do_wr(8'h46, 8'h02);
    check("R4 pclk_mode cleared", pclk_mode, 0);
    repeat (LOCK + 2) @(negedge clk);
    check("R5 clk_fail stays clear", clk_fail, 0);
  endtask

  task automatic t_reads;
    logic [7:0] d;
    do_wr(8'h4A, 8'h04);
    do_rd(8'h10, d); check("R7 single channel 3", d, 8'hC3);
    check("R7 rd_valid", rd_valid, 1);
    do_rd(8'h5A, d); check("R8 no error single read", d, 8'h06);
    do_wr(8'h4A, 8'h06);
    do_rd(8'h10, d); check("R7 lowest of ch2,ch3", d, 8'hB2);
    do_rd(8'h5A, d); check("R8 error set", d, 8'h46);
    do_wr(8'h4A, 8'h00);
    do_rd(8'h10, d); check("R7 empty mask reads 0", d, 8'h00);
    do_rd(8'h5A, d); check("R8 error sticky", d, 8'h46);
  endtask

  task automatic t_cs_reset;
    logic [7:0] d;
    do_wr(8'h4A, 8'h09);
    cs_pulse(15);
    check("R9 15 edges no pulse", pulses, 0);
    check("R9 state kept", active, 4'b0110);
    cs_pulse(16);
    check("R9 16 edges one pulse", pulses, 1);
    check("R10 active cleared", active, 0);
    check("R10 clk_fail set", clk_fail, 1);
    do_rd(8'h4A, d); check("R10 mask cleared", d, 0);
    do_rd(8'h5A, d); check("R10 status", d, 8'h80);
    do_rd(8'h46, d); check("R10 clksel cleared", d, 0);
    cs_pulse(20);
    check("R9 saturated one pulse", pulses, 2);
  endtask

  task automatic t_pin_reset;
    logic [7:0] d;
    do_wr(8'h46, 8'h11);
    repeat (LOCK + 1) @(negedge clk);
    do_wr(8'h4A, 8'h0F); do_wr(8'h0E, 8'h00);
    check("R6 broadcast activate", active, 4'hF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R11 active", active, 0);
    check("R11 clk_fail", clk_fail, 1);
    check("R11 pclk_mode", pclk_mode, 0);
    do_rd(8'h4A, d); check("R11 mask", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state;
    t_fanout;
    t_act_blocked;
    t_clk_lock;
    t_activation;
    t_reads;
    t_cs_reset;
    t_pin_reset;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule